// File: doc/BRIEF.md
# Parameterized Maximal-Length Pseudorandom Pattern Generator

This block is a shift-register pattern source for built-in self-test. Every enabled clock it shifts its contents one place toward the most significant bit. A feedback bit enters at bit 0, formed as the XOR of a few tap positions. The register length is a parameter from 2 to 9. The tap positions come from a fixed table inside the block, keyed by that length. With those taps the register visits every nonzero value exactly once before it repeats.

A typical use is a 9-bit instance that drives a 4-bit adder under test. Eight of its bits feed the two operands and the ninth feeds the carry-in. A synchronous reset loads a nonzero seed, which is all ones by default. A seed parameter whose in-range bits are all zero is replaced by all ones, so the register cannot start in the stuck all-zero state. When the enable is low the register holds its value.

Top module: `lfsr_pattern_gen`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `pattern` equals the seed, which is the low LEN bits of parameter SEED (default all ones).
- R2: On each clock edge with `rst` low and `en` high, `pattern[LEN-1:1]` takes the previous `pattern[LEN-2:0]`, and bit 0 takes the feedback bit.
- R3: The feedback bit is the XOR of these tap bits: length 2 uses bits 1,0; length 3 uses 2,0; length 4 uses 3,0; length 5 uses 4,1; length 6 uses 5,0; length 7 uses 6,2; length 9 uses 8,3.
- R4: For length 8 the feedback is the XOR of bits 7, 3, 2 and 1, built as two two-input XORs that feed a third.
- R5: On a clock edge with `rst` low and `en` low, `pattern` keeps its value.
- R6: Starting from the all-ones seed with `en` held high, every length from 2 to 9 first returns to the seed after exactly 2^LEN−1 steps, and `pattern` is never zero along the way.
- R7: Reset is synchronous and takes priority over `en`. A reset while `en` is high still loads the seed.
- R8: If the low LEN bits of SEED are all zero, reset loads all ones instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, loads the seed |
| en | input | 1 | Advance enable, active high |
| pattern | output | LEN | Current register contents, used as the test pattern |

## Verification
The bench runs one instance of each length from 2 to 9 side by side. It compares every step against a model built from the tap table and measures the cycle at which each instance first returns to its seed. A wrong tap or a swapped tap pair shows up as a short cycle or a mismatched step. A shift in the wrong direction breaks the step-by-step comparison at once. An 8-bit tree that drops or repeats a leg fails only at that length. Other tests check that a low enable holds the value, that reset overrides enable in the middle of a run, and that a nonzero seed and an all-zero seed each load the value R1 and R8 require. A design that let a zero seed through would show zero and stay there.

// File: rtl/lfsr_pkg.sv
`timescale 1ns/1ps
package lfsr_pkg;

  localparam int MAX_LEN = 9;

  // Strobes that the control half sends to the datapath half.
  typedef struct packed {
    logic load;
    logic step;
  } lfsrStrobe_t;

  // Tap positions, one bit per position, keyed by register length.
  function automatic logic [MAX_LEN-1:0] tapMask(input int len);
    logic [MAX_LEN-1:0] m;
    m = '0;
    case (len)
      2: begin m[1] = 1'b1; m[0] = 1'b1; end
      3: begin m[2] = 1'b1; m[0] = 1'b1; end
      4: begin m[3] = 1'b1; m[0] = 1'b1; end
      5: begin m[4] = 1'b1; m[1] = 1'b1; end
      6: begin m[5] = 1'b1; m[0] = 1'b1; end
      7: begin m[6] = 1'b1; m[2] = 1'b1; end
      8: begin m[7] = 1'b1; m[3] = 1'b1; m[2] = 1'b1; m[1] = 1'b1; end
      9: begin m[8] = 1'b1; m[3] = 1'b1; end
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lfsr_ctrl.sv
`timescale 1ns/1ps
module lfsr_ctrl
  import lfsr_pkg::*;
(
  input  logic        rst,
  input  logic        en,
  output lfsrStrobe_t strobe
);

  // Reset wins over enable; otherwise enable advances the register.
  always_comb begin
    strobe.load = rst;
    strobe.step = en & ~rst;
  end

endmodule

// File: rtl/lfsr_datapath.sv
`timescale 1ns/1ps
module lfsr_datapath
  import lfsr_pkg::*;
#(
  parameter int               LEN  = 9,
  parameter logic [MAX_LEN-1:0] SEED = '1
) (
  input  logic           clk,
  input  lfsrStrobe_t    strobe,
  output logic [LEN-1:0] stateOut
);

  localparam logic [MAX_LEN-1:0] TAPS_FULL = tapMask(LEN);
  localparam logic [LEN-1:0]     TAPS      = TAPS_FULL[LEN-1:0];
  localparam logic [LEN-1:0]     SEED_RAW  = SEED[LEN-1:0];
  // An all-zero seed would lock the register; fall back to all ones.
  localparam logic [LEN-1:0]     SEED_EFF  = (SEED_RAW == '0) ? '1 : SEED_RAW;

  logic [LEN-1:0] stateQ;
  logic           feedback;

  generate
    if (LEN < 2 || LEN > MAX_LEN) begin : g_badLen
      $error("lfsr_datapath: LEN must lie between 2 and 9");
    end
    if (LEN == 8) begin : g_tree
      // Four taps: two pair XORs feeding a final XOR.
      logic pairLo;
      logic pairHi;
      always_comb begin
        pairLo   = stateQ[1] ^ stateQ[2];
        pairHi   = stateQ[3] ^ stateQ[7];
        feedback = pairLo ^ pairHi;
      end
    end else begin : g_pair
      always_comb feedback = ^(stateQ & TAPS);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      stateQ <= SEED_EFF;
    end else if (strobe.step) begin
      stateQ <= {stateQ[LEN-2:0], feedback};
    end
  end

  assign stateOut = stateQ;

endmodule

// File: rtl/lfsr_pattern_gen.sv
`timescale 1ns/1ps
module lfsr_pattern_gen
  import lfsr_pkg::*;
#(
  parameter int                 LEN  = 9,
  parameter logic [MAX_LEN-1:0] SEED = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  output logic [LEN-1:0] pattern
);

  lfsrStrobe_t strobe;

  lfsr_ctrl i_ctrl (
    .rst    (rst),
    .en     (en),
    .strobe (strobe)
  );

  lfsr_datapath #(
    .LEN  (LEN),
    .SEED (SEED)
  ) i_datapath (
    .clk      (clk),
    .strobe   (strobe),
    .stateOut (pattern)
  );

endmodule

// File: rtl/lfsr_pattern_gen_chk.sv
`timescale 1ns/1ps
module lfsr_pattern_gen_chk
  import lfsr_pkg::*;
#(
  parameter int                 LEN  = 9,
  parameter logic [MAX_LEN-1:0] SEED = '1
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic [LEN-1:0] pattern
);

  localparam logic [LEN-1:0] SEED_RAW = SEED[LEN-1:0];
  localparam logic [LEN-1:0] SEED_EFF = (SEED_RAW == '0) ? '1 : SEED_RAW;

  logic rstQ = 1'b0;
  logic seenReset = 1'b0;

  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rst) seenReset <= 1'b1;
  end

  always_ff @(negedge clk) begin
    // R1 R7 R8
    if (rstQ) begin
      seed_load_chk : assert (pattern == SEED_EFF)
        else $error("pattern %h after reset, seed %h", pattern, SEED_EFF);
    end
    // R6
    if (seenReset && !rstQ) begin
      never_zero_chk : assert (pattern != '0)
        else $error("pattern reached zero");
    end
  end

  // R2
  shift_up_chk : assert property (@(posedge clk) disable iff (rst)
    en |=> pattern[LEN-1:1] == $past(pattern[LEN-2:0]));

  // R5
  hold_chk : assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pattern));

endmodule

bind lfsr_pattern_gen lfsr_pattern_gen_chk #(
  .LEN  (LEN),
  .SEED (SEED)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .pattern (pattern)
);

// File: tb/test_lfsr_pattern_gen.sv
`timescale 1ns/1ps
module test_lfsr_pattern_gen;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  int   checks = 0;
  int   errors = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  logic [8:0]      patMain;
  logic [8:0]      patSeeded;
  logic [4:0]      patZeroSeed;
  logic [9:2][8:0] allOut;

  lfsr_pattern_gen #(.LEN(9)) i_lfsr_pattern_gen (
    .clk(clk), .rst(rst), .en(en), .pattern(patMain));

  lfsr_pattern_gen #(.LEN(9), .SEED(9'h0A5)) i_seeded (
    .clk(clk), .rst(rst), .en(en), .pattern(patSeeded));

  lfsr_pattern_gen #(.LEN(5), .SEED(9'h000)) i_zeroSeed (
    .clk(clk), .rst(rst), .en(en), .pattern(patZeroSeed));

  for (genvar g = 2; g <= 8; g++) begin : g_len
    logic [g-1:0] pat;
    lfsr_pattern_gen #(.LEN(g)) i_len (
      .clk(clk), .rst(rst), .en(en), .pattern(pat));
    assign allOut[g] = 9'(pat);
  end
  assign allOut[9] = patMain;

  function automatic logic [8:0] lenMask(input int n);
    return 9'((10'h1 << n) - 10'h1);
  endfunction

  // Independent next-state model from the tap table in R3/R4.
  function automatic logic [8:0] modelNext(input logic [8:0] s, input int n);
    logic fb;
    case (n)
      2: fb = s[1] ^ s[0];
      3: fb = s[2] ^ s[0];
      4: fb = s[3] ^ s[0];
      5: fb = s[4] ^ s[1];
      6: fb = s[5] ^ s[0];
      7: fb = s[6] ^ s[2];
      8: fb = s[7] ^ s[3] ^ s[2] ^ s[1];
      9: fb = s[8] ^ s[3];
      default: fb = 1'b0;
    endcase
    return ({s[7:0], fb}) & lenMask(n);
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic enVal);
    @(negedge clk);
    rst = 1'b1; en = enVal;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // R1 R8: seed values right after reset
  task automatic testResetState();
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    @(negedge clk);
    check("R1 default seed", patMain, 9'h1FF);
    check("R1 custom seed", patSeeded, 9'h0A5);
    check("R8 zero seed replaced", 9'(patZeroSeed), 9'h01F);
    rst = 1'b0;
  endtask

  // R2 R3: step-by-step against the model for the two 9-bit instances
  task automatic testSteps();
    logic [8:0] expMain;
    logic [8:0] expSeed;
    doReset(1'b0);
    expMain = 9'h1FF;
    expSeed = 9'h0A5;
    en = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      expMain = modelNext(expMain, 9);
      expSeed = modelNext(expSeed, 9);
      check("R2 R3 step main", patMain, expMain);
      check("R2 R3 step seeded", patSeeded, expSeed);
    end
    en = 1'b0;
  endtask

  // R5: enable low holds every instance
  task automatic testHold();
    logic [8:0] keepMain;
    logic [8:0] keep8;
    @(negedge clk);
    en = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b0;
    keepMain = patMain;
    keep8    = allOut[8];
    repeat (5) @(negedge clk);
    check("R5 hold main", patMain, keepMain);
    check("R5 hold len8", allOut[8], keep8);
    en = 1'b1;
    @(negedge clk);
    check("R5 resumes after hold", patMain, modelNext(keepMain, 9));
    en = 1'b0;
  endtask

  // R7: reset in mid-run with enable high still loads the seed
  task automatic testResetPriority();
    @(negedge clk);
    en = 1'b1;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R7 reset over enable main", patMain, 9'h1FF);
    check("R7 reset over enable seeded", patSeeded, 9'h0A5);
    @(negedge clk);
    check("R7 held in reset", patMain, 9'h1FF);
    rst = 1'b0;
    en  = 1'b0;
  endtask

  // R3 R4 R6: all lengths, stepwise match and full period
  task automatic testPeriods();
    int         firstRet [9:2];
    logic [8:0] expSt    [9:2];
    int         zeroSeen [9:2];
    int         mism     [9:2];
    doReset(1'b0);
    for (int g = 2; g <= 9; g++) begin
      firstRet[g] = 0;
      zeroSeen[g] = 0;
      mism[g]     = 0;
      expSt[g]    = lenMask(g);
    end
    en = 1'b1;
    for (int cyc = 1; cyc <= 520; cyc++) begin
      @(negedge clk);
      for (int g = 2; g <= 9; g++) begin
        expSt[g] = modelNext(expSt[g], g);
        if (allOut[g] !== expSt[g]) mism[g]++;
        if (allOut[g] == 9'h000) zeroSeen[g]++;
        if (firstRet[g] == 0 && allOut[g] == lenMask(g)) firstRet[g] = cyc;
      end
    end
    en = 1'b0;
    for (int g = 2; g <= 9; g++) begin
      if (g == 8) check("R4 len8 tap tree mismatches", 9'(mism[g]), 9'h0);
      else        check("R3 tap table mismatches", 9'(mism[g]), 9'h0);
      check("R6 period", 9'(firstRet[g]), 9'((1 << g) - 1));
      check("R6 never zero", 9'(zeroSeen[g]), 9'h0);
    end
  endtask

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    testResetState();
    testSteps();
    testHold();
    testResetPriority();
    testPeriods();
    finished = 1'b1;
    finish();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

endmodule